// File: doc/BRIEF.md
# Isochronous IN Transmit Ping-Pong Buffer

This block is the transmit store for one isochronous IN endpoint of a USB device. It holds two equal banks of byte storage. At any time one bank belongs to the local host, which fills it through a plain write strobe, and the other belongs to the USB serial engine, which drains it byte by byte when an IN token calls for data. Neither side ever waits for the other, and no enable or ownership bit gates either port.

The two roles change hands only at a start-of-frame event. On that event the host bank becomes the transmit bank and the old transmit bank is emptied and handed back to the host. Any bytes that the USB side did not send during the frame are discarded. A start-of-frame reported with a bad packet counts the same as a good one. Each such event also raises a level interrupt that asks the host to refill its bank. A finished IN transfer raises no interrupt of its own.

The usable depth of each bank is set at run time by a length input, up to a build-time maximum. A host write to a full bank is dropped and latches a sticky overflow flag. A USB read of an empty bank returns a zero-length indication and no data.

Top module: `iso_tx_pingpong`

## Requirements
- R1: After reset, fg_sel is 0, both fg_count and bg_count are 0, bg_empty is 1, and ovf_flag, sof_irq, usb_rd_valid and usb_rd_zlen are all 0.
- R2: A host write with host_wr_en=1 stores one byte in the host-side bank, so fg_count rises by one. It does not change bg_count, even in a cycle where the USB side is reading.
- R3: The host bank is full when fg_count equals cfg_len, with cfg_len limited to MAX_LEN. A write to a full bank is dropped and sets ovf_flag. ovf_flag stays at 1 until host_ovf_clr is pulsed. If a dropped write and host_ovf_clr fall in the same cycle, the flag stays at 1.
- R4: A start-of-frame event is a cycle with sof_ok=1 or sof_bad=1. Each event inverts fg_sel. The bytes held by the former host bank then appear as bg_count, and the new host bank reads fg_count=0.
- R5: A host write in the same cycle as a start-of-frame event lands in the bank that was host-side before the swap. That bank has just become the transmit bank, so bg_count equals the previous fg_count plus one, and the byte is sent last.
- R6: A read with usb_rd_en=1 from a non-empty transmit bank sets usb_rd_valid to 1 and places the next byte on usb_rd_data in the following cycle. Bytes come out in the order they were written. Each read lowers bg_count by one.
- R7: A read with usb_rd_en=1 while bg_count is 0 gives usb_rd_zlen=1 and usb_rd_valid=0 in the following cycle, and bg_count stays at 0.
- R8: Once every byte of the transmit bank has been read, bg_empty is 1.
- R9: sof_irq is set by every start-of-frame event, including one signalled only by sof_bad. It stays at 1 until host_sof_clr is pulsed. A further event while it is set leaves it set. An event in the same cycle as host_sof_clr leaves it set.
- R10: At a start-of-frame event, bytes left unread in the transmit bank are discarded. After two events with no reads in between, both fg_count and bg_count are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len | input | CW | Endpoint length in bytes (limited to MAX_LEN) |
| host_wr_en | input | 1 | Host byte write strobe |
| host_wr_data | input | DATA_W | Host write byte |
| host_ovf_clr | input | 1 | Clears the overflow flag |
| host_sof_clr | input | 1 | Clears the frame interrupt |
| sof_ok | input | 1 | Start-of-frame received intact |
| sof_bad | input | 1 | Start-of-frame received corrupted |
| usb_rd_en | input | 1 | USB engine byte read request |
| usb_rd_data | output | DATA_W | Byte read from the transmit bank |
| usb_rd_valid | output | 1 | usb_rd_data holds a byte |
| usb_rd_zlen | output | 1 | Read found the transmit bank empty |
| bg_empty | output | 1 | Transmit bank holds no bytes |
| fg_count | output | CW | Bytes held in the host bank |
| bg_count | output | CW | Bytes left in the transmit bank |
| fg_sel | output | 1 | Index of the bank owned by the host |
| ovf_flag | output | 1 | Sticky host write overflow |
| sof_irq | output | 1 | Frame interrupt level |

## Verification
The collision of interest is a start-of-frame swap landing in the same cycle as a host write. A write on the swap edge could go to either bank, and it must not be lost to the clear. The bench raises sof_ok and host_wr_en in one cycle. It then expects the transmit bank to report the old host count plus one, and drains that bank to confirm the new byte comes out last. Two further same-cycle pairs are judged by their flags: a frame event together with host_sof_clr, and a dropped write together with host_ovf_clr. In both cases the set must win.

// File: rtl/iso_pp_pkg.sv
package iso_pp_pkg;
  typedef enum logic [0:0] {BANK_0 = 1'b0, BANK_1 = 1'b1} bank_e;

  function automatic bank_e other_bank(bank_e b);
    return (b == BANK_0) ? BANK_1 : BANK_0;
  endfunction
endpackage

// File: rtl/iso_pp_bank.sv
module iso_pp_bank #(
  parameter int DATA_W  = 8,
  parameter int MAX_LEN = 64,
  localparam int AW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
  localparam int CW = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_q,
  output logic [CW-1:0]     wptr,
  output logic [CW-1:0]     rptr
);
  logic [DATA_W-1:0] mem [MAX_LEN];

  // storage: no reset so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_en) wptr <= wptr + 1'b1;
      if (rd_en) rptr <= rptr + 1'b1;
    end
  end

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (wptr == '0 && rptr == '0)); // R10
  AST_RD_BEHIND_WR: assert property (@(posedge clk) disable iff (rst)
    rptr <= wptr); // R8
endmodule

// File: rtl/iso_pp_flags.sv
module iso_pp_flags (
  input  logic clk,
  input  logic rst,
  input  logic sof_evt,
  input  logic irq_clr,
  input  logic ovf_set,
  input  logic ovf_clr,
  output logic sof_irq,
  output logic ovf_flag
);
  // set has priority over clear for both flags
  always_ff @(posedge clk) begin
    if (rst) begin
      sof_irq  <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (sof_evt)      sof_irq <= 1'b1;
      else if (irq_clr) sof_irq <= 1'b0;
      if (ovf_set)      ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
    end
  end

  AST_IRQ_ON_SOF: assert property (@(posedge clk) disable iff (rst)
    sof_evt |=> sof_irq); // R9
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sof_irq && !irq_clr) |=> sof_irq); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag); // R3
endmodule

// File: rtl/iso_tx_pingpong.sv
module iso_tx_pingpong
  import iso_pp_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MAX_LEN = 64,
  localparam int CW = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     cfg_len,
  input  logic              host_wr_en,
  input  logic [DATA_W-1:0] host_wr_data,
  input  logic              host_ovf_clr,
  input  logic              host_sof_clr,
  input  logic              sof_ok,
  input  logic              sof_bad,
  input  logic              usb_rd_en,
  output logic [DATA_W-1:0] usb_rd_data,
  output logic              usb_rd_valid,
  output logic              usb_rd_zlen,
  output logic              bg_empty,
  output logic [CW-1:0]     fg_count,
  output logic [CW-1:0]     bg_count,
  output logic              fg_sel,
  output logic              ovf_flag,
  output logic              sof_irq
);
  localparam logic [CW-1:0] MAX_C = CW'(MAX_LEN);

  bank_e              sel_q;
  bank_e              bg_b;
  bank_e              rd_bank_q;
  logic               sof_evt;
  logic               fg_full;
  logic               wr_ok;
  logic               rd_ok;
  logic [CW-1:0]      limit;
  logic [1:0]         b_wr;
  logic [1:0]         b_rd;
  logic [1:0]         b_clr;
  logic [CW-1:0]      b_wptr [2];
  logic [CW-1:0]      b_rptr [2];
  logic [DATA_W-1:0]  b_q    [2];

  assign sof_evt = sof_ok | sof_bad;
  assign bg_b    = other_bank(sel_q);
  assign limit   = (cfg_len > MAX_C) ? MAX_C : cfg_len;

  assign fg_count = b_wptr[sel_q] - b_rptr[sel_q];
  assign bg_count = b_wptr[bg_b]  - b_rptr[bg_b];
  assign bg_empty = (bg_count == '0);
  assign fg_full  = (fg_count >= limit);
  assign wr_ok    = host_wr_en & ~fg_full;
  assign rd_ok    = usb_rd_en & ~bg_empty;

  // bank select: toggles on each frame event
  always_ff @(posedge clk) begin
    if (rst) sel_q <= BANK_0;
    else if (sof_evt) sel_q <= bg_b;
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    // writes and reads use the pre-swap roles; clear hits the old background
    assign b_wr[b]  = wr_ok & (sel_q == bank_e'(b));
    assign b_rd[b]  = rd_ok & (bg_b == bank_e'(b));
    assign b_clr[b] = sof_evt & (bg_b == bank_e'(b));

    iso_pp_bank #(.DATA_W(DATA_W), .MAX_LEN(MAX_LEN)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .clr     (b_clr[b]),
      .wr_en   (b_wr[b]),
      .wr_data (host_wr_data),
      .rd_en   (b_rd[b]),
      .rd_q    (b_q[b]),
      .wptr    (b_wptr[b]),
      .rptr    (b_rptr[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      usb_rd_valid <= 1'b0;
      usb_rd_zlen  <= 1'b0;
      rd_bank_q    <= BANK_0;
    end else begin
      usb_rd_valid <= rd_ok;
      usb_rd_zlen  <= usb_rd_en & bg_empty;
      if (rd_ok) rd_bank_q <= bg_b;
    end
  end

  assign usb_rd_data = b_q[rd_bank_q];
  assign fg_sel      = sel_q;

  iso_pp_flags u_flags (
    .clk      (clk),
    .rst      (rst),
    .sof_evt  (sof_evt),
    .irq_clr  (host_sof_clr),
    .ovf_set  (host_wr_en & fg_full),
    .ovf_clr  (host_ovf_clr),
    .sof_irq  (sof_irq),
    .ovf_flag (ovf_flag)
  );

  AST_SWAP_ON_SOF: assert property (@(posedge clk) disable iff (rst)
    sof_evt |=> (fg_sel != $past(fg_sel))); // R4
  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (rst)
    !sof_evt |=> $stable(fg_sel)); // R4
  AST_NEW_FG_EMPTY: assert property (@(posedge clk) disable iff (rst)
    sof_evt |=> (fg_count == '0)); // R10
  AST_ZLEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (usb_rd_en && bg_empty) |=> (usb_rd_zlen && !usb_rd_valid)); // R7
  AST_VALID_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({usb_rd_valid, usb_rd_zlen})); // R6
endmodule

// File: tb/sim_iso_tx_pingpong.sv
module sim_iso_tx_pingpong;
  localparam int DW = 8;
  localparam int ML = 64;
  localparam int CW = $clog2(ML + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] cfg_len = CW'(16);
  logic host_wr_en = 0, host_ovf_clr = 0, host_sof_clr = 0;
  logic [DW-1:0] host_wr_data = '0;
  logic sof_ok = 0, sof_bad = 0, usb_rd_en = 0;
  logic [DW-1:0] usb_rd_data;
  logic usb_rd_valid, usb_rd_zlen, bg_empty, fg_sel, ovf_flag, sof_irq;
  logic [CW-1:0] fg_count, bg_count;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  iso_tx_pingpong #(.DATA_W(DW), .MAX_LEN(ML)) u0 (
    .clk(clk), .rst(rst), .cfg_len(cfg_len),
    .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .host_ovf_clr(host_ovf_clr), .host_sof_clr(host_sof_clr),
    .sof_ok(sof_ok), .sof_bad(sof_bad), .usb_rd_en(usb_rd_en),
    .usb_rd_data(usb_rd_data), .usb_rd_valid(usb_rd_valid),
    .usb_rd_zlen(usb_rd_zlen), .bg_empty(bg_empty),
    .fg_count(fg_count), .bg_count(bg_count), .fg_sel(fg_sel),
    .ovf_flag(ovf_flag), .sof_irq(sof_irq)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [DW-1:0] d);
    host_wr_en = 1; host_wr_data = d;
    tick();
    host_wr_en = 0;
  endtask

  task automatic sof(input logic bad);
    if (bad) sof_bad = 1; else sof_ok = 1;
    tick();
    sof_ok = 0; sof_bad = 0;
  endtask

  task automatic rd_expect(input logic [DW-1:0] d, input string tag);
    usb_rd_en = 1;
    tick();
    usb_rd_en = 0;
    check(usb_rd_valid, 1, {tag, " valid"});
    check(usb_rd_data, d, {tag, " data"});
  endtask

  task automatic t_reset();
    check(fg_sel, 0, "R1 fg_sel");
    check(fg_count, 0, "R1 fg_count");
    check(bg_count, 0, "R1 bg_count");
    check(bg_empty, 1, "R1 bg_empty");
    check({ovf_flag, sof_irq, usb_rd_valid, usb_rd_zlen}, 0, "R1 flags");
  endtask

  task automatic t_fill_swap();
    for (int i = 0; i < 3; i++) wr(8'hA0 + 8'(i));
    check(fg_count, 3, "R2 fg_count after writes");
    check(bg_count, 0, "R2 bg_count untouched");
    sof(1'b0);
    check(fg_sel, 1, "R4 fg_sel toggled");
    check(bg_count, 3, "R4 bg_count takes old fg");
    check(fg_count, 0, "R4 new fg empty");
    check(sof_irq, 1, "R9 irq on sof_ok");
  endtask

  task automatic t_read();
    // first read overlaps a host write
    usb_rd_en = 1; host_wr_en = 1; host_wr_data = 8'hB0;
    tick();
    usb_rd_en = 0; host_wr_en = 0;
    check(usb_rd_valid, 1, "R6 valid 0");
    check(usb_rd_data, 8'hA0, "R6 data 0");
    check(fg_count, 1, "R2 write during read");
    check(bg_count, 2, "R6 bg_count decrement");
    rd_expect(8'hA1, "R6 byte 1");
    rd_expect(8'hA2, "R6 byte 2");
    check(bg_empty, 1, "R8 empty after drain");
    usb_rd_en = 1;
    tick();
    usb_rd_en = 0;
    check(usb_rd_zlen, 1, "R7 zlen");
    check(usb_rd_valid, 0, "R7 no valid");
    check(bg_count, 0, "R7 bg_count stays 0");
    check(fg_count, 1, "R2 fg untouched by reads");
  endtask

  task automatic t_overflow();
    cfg_len = CW'(4);
    for (int i = 1; i < 4; i++) wr(8'hB0 + 8'(i));
    check(fg_count, 4, "R3 fill to cfg_len");
    check(ovf_flag, 0, "R3 no ovf at limit");
    wr(8'hEE);
    check(fg_count, 4, "R3 write dropped");
    check(ovf_flag, 1, "R3 ovf set");
    host_ovf_clr = 1; tick(); host_ovf_clr = 0;
    check(ovf_flag, 0, "R3 ovf cleared");
    host_ovf_clr = 1; host_wr_en = 1; host_wr_data = 8'hEE;
    tick();
    host_ovf_clr = 0; host_wr_en = 0;
    check(ovf_flag, 1, "R3 set beats clear");
    host_ovf_clr = 1; tick(); host_ovf_clr = 0;
    cfg_len = CW'(16);
  endtask

  task automatic t_sof_collide();
    host_sof_clr = 1; tick(); host_sof_clr = 0;
    check(sof_irq, 0, "R9 irq cleared");
    sof_ok = 1; host_wr_en = 1; host_wr_data = 8'hB4;
    tick();
    sof_ok = 0; host_wr_en = 0;
    check(fg_sel, 0, "R5 swapped");
    check(bg_count, 5, "R5 write lands in new bg");
    check(fg_count, 0, "R5 new fg empty");
    for (int i = 0; i < 5; i++) rd_expect(8'hB0 + 8'(i), "R5 R6 order");
    check(bg_empty, 1, "R8 empty after collide drain");
  endtask

  task automatic t_discard_irq();
    wr(8'hC0); wr(8'hC1);
    sof(1'b0);
    check(bg_count, 2, "R10 bg before discard");
    host_sof_clr = 1; tick(); host_sof_clr = 0;
    check(sof_irq, 0, "R9 irq clear");
    sof(1'b1);
    check(fg_sel, 0, "R4 swap on sof_bad");
    check(fg_count, 0, "R10 unread discarded");
    check(bg_count, 0, "R10 other bank empty");
    check(sof_irq, 1, "R9 irq on sof_bad");
    sof(1'b0);
    check(sof_irq, 1, "R9 irq stays set");
    sof_ok = 1; host_sof_clr = 1;
    tick();
    sof_ok = 0; host_sof_clr = 0;
    check(sof_irq, 1, "R9 sof beats clear");
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    rst = 0;
    tick();
    t_reset();
    t_fill_swap();
    t_read();
    t_overflow();
    t_sof_collide();
    t_discard_irq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule